// File: doc/BRIEF.md
# SPI FIFO and Interrupt Unit

This block is the host-side buffering and event logic of a serial peripheral controller. A host writes words into a transmit queue through a simple register port, and a serial engine drains that queue one word at a time. In the other direction the engine pushes received words into a receive queue, and the host pops them by reading a data port. Around the two queues the block reports fill levels and a five-bit status word. It raises an interrupt from five event sources under a mask, and it issues per-direction DMA requests against programmable watermarks.

The register port is word addressed and has a 6-bit address. Reads are combinational in the cycle that `regRdEn` is high. Writes take effect at the clock edge that samples `regWrEn`. A read of the receive data port removes the word it returns. The transmit head word is always visible to the engine on `txWord`, and `txPop` consumes it. Both queue thresholds only store values below the queue depth, so software can discover the depth by writing growing values and reading them back.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset the unit is disabled, both levels read 0, status reads 12, the raw event word reads 1, both thresholds read 0, and `irq`, `txDmaReq`, `rxDmaReq` and `txValid` are low.
- R2: While enabled, a write to the transmit data port (0x10) that finds room appends the word. The transmit level (0x03) counts the stored words, and the engine sees them on `txWord` in write order, each `txPop` removing the head; `txValid` is high exactly when the queue holds a word.
- R3: While enabled, an `rxPush` that finds room stores `rxWord`. A read of the receive data port (0x20) returns the oldest stored word and removes it, and the receive level (0x04) counts the stored words.
- R4: Status (0x05) is bit 0 busy (`engBusy`, or enabled with transmit data waiting), bit 1 transmit full, bit 2 transmit empty, bit 3 receive empty, bit 4 receive full.
- R5: A data-port write while the transmit queue is full leaves the queue and its level unchanged and sets sticky raw event bit 1 (transmit overflow).
- R6: A receive data read with the queue empty returns 0 and sets sticky bit 2 (receive underflow). An `rxPush` into a full receive queue discards the word and sets sticky bit 3 (receive overflow).
- R7: Raw event (0x08) bit 0 is high while the transmit level is at or below the transmit threshold (0x01), and bit 4 is high while the receive level is above the receive threshold (0x02).
- R8: The masked event word (0x07) is the raw word ANDed with the 5-bit mask (0x06), and `irq` is high exactly when any masked bit is set.
- R9: A write to the clear register (0x09) with bit 1 set clears receive underflow, with bit 2 set clears receive overflow, with bit 3 set clears transmit overflow, and with bit 0 set clears all three; the register reads 0.
- R10: A threshold write holds only when the value is below the queue depth. Any other value is dropped, and the previous value reads back.
- R11: DMA control (0x0A) bit 0 enables `rxDmaReq`, which is high while the receive level exceeds the receive watermark (0x0C). Bit 1 enables `txDmaReq`, which is high while the transmit level is at or below the transmit watermark (0x0B).
- R12: While the enable bit (0x00 bit 0) is low, both queues are held empty. Data-port writes and engine pushes are then dropped without setting overflow, and normal operation resumes once the bit is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register word address |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data, valid while `regRdEn` is high |
| txWord | output | DATA_W | Head of the transmit queue |
| txValid | output | 1 | Transmit queue holds at least one word |
| txPop | input | 1 | Engine consumes the transmit head |
| rxWord | input | DATA_W | Word received by the engine |
| rxPush | input | 1 | Engine delivers `rxWord` |
| engBusy | input | 1 | Serial engine is mid-transfer |
| irq | output | 1 | OR of masked event bits |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |

## Verification
Register reads, status, the masked word, `irq` and the DMA requests are combinational from state. A write, push or pop therefore shows in all of them one clock edge after the cycle that carries it, and a read returns the state left by the previous edge. The bench drives every input at a falling edge and holds it for one full cycle. Data-port reads and head words are sampled just after that falling edge, before the edge that pops them. Level, status and flag checks are taken in a later read cycle, after the causing edge has passed.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  // Strobes from the control to the queue datapath
  typedef struct packed {
    logic flush;
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
  } fifoStrobes_t;

  // Register word addresses
  localparam int unsigned A_ENABLE   = 'h00;
  localparam int unsigned A_TXTHR    = 'h01;
  localparam int unsigned A_RXTHR    = 'h02;
  localparam int unsigned A_TXLVL    = 'h03;
  localparam int unsigned A_RXLVL    = 'h04;
  localparam int unsigned A_STATUS   = 'h05;
  localparam int unsigned A_MASK     = 'h06;
  localparam int unsigned A_MASKED   = 'h07;
  localparam int unsigned A_RAW      = 'h08;
  localparam int unsigned A_CLEAR    = 'h09;
  localparam int unsigned A_DMACTL   = 'h0A;
  localparam int unsigned A_TXWM     = 'h0B;
  localparam int unsigned A_RXWM     = 'h0C;
  localparam int unsigned A_TXDATA   = 'h10;
  localparam int unsigned A_RXDATA   = 'h20;

  localparam int unsigned EVENT_N = 5;

endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         flush,
  input  logic                         push,
  input  logic                         pop,
  input  logic [WIDTH-1:0]             wdata,
  output logic [WIDTH-1:0]             head,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rdPtr];
  assign level = count;
endmodule

// File: rtl/sfc_datapath.sv
module sfc_datapath import sfc_pkg::*; #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fifoStrobes_t               strb,
  input  logic [DATA_W-1:0]          txIn,
  input  logic [DATA_W-1:0]          rxIn,
  output logic [DATA_W-1:0]          txHead,
  output logic [DATA_W-1:0]          rxHead,
  output logic [$clog2(DEPTH+1)-1:0] txLevel,
  output logic [$clog2(DEPTH+1)-1:0] rxLevel
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned DIRS  = 2;  // index 0 transmit, 1 receive

  logic              pushV  [DIRS];
  logic              popV   [DIRS];
  logic [DATA_W-1:0] dataV  [DIRS];
  logic [DATA_W-1:0] headV  [DIRS];
  logic [CNT_W-1:0]  levelV [DIRS];

  assign pushV[0] = strb.txPush;
  assign popV[0]  = strb.txPop;
  assign dataV[0] = txIn;
  assign pushV[1] = strb.rxPush;
  assign popV[1]  = strb.rxPop;
  assign dataV[1] = rxIn;

  for (genvar d = 0; d < DIRS; d++) begin : g_queue
    sfc_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rstN  (rstN),
      .flush (strb.flush),
      .push  (pushV[d]),
      .pop   (popV[d]),
      .wdata (dataV[d]),
      .head  (headV[d]),
      .level (levelV[d])
    );
  end

  assign txHead  = headV[0];
  assign rxHead  = headV[1];
  assign txLevel = levelV[0];
  assign rxLevel = levelV[1];
endmodule

// File: rtl/sfc_control.sv
module sfc_control import sfc_pkg::*; #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWrEn,
  input  logic                       regRdEn,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [DATA_W-1:0]          regWrData,
  output logic [DATA_W-1:0]          regRdData,
  input  logic                       txPop,
  input  logic                       rxPush,
  input  logic                       engBusy,
  input  logic [DATA_W-1:0]          txHead,
  input  logic [DATA_W-1:0]          rxHead,
  input  logic [$clog2(DEPTH+1)-1:0] txLevel,
  input  logic [$clog2(DEPTH+1)-1:0] rxLevel,
  output fifoStrobes_t               strb,
  output logic                       enabled,
  output logic                       txValid,
  output logic                       irq,
  output logic                       txDmaReq,
  output logic                       rxDmaReq
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic               enableQ;
  logic [PTR_W-1:0]   txThrQ, rxThrQ;
  logic [EVENT_N-1:0] maskQ;
  logic               txOvfQ, rxUdfQ, rxOvfQ;
  logic [1:0]         dmaCtlQ;
  logic [CNT_W-1:0]   txWmQ, rxWmQ;

  logic txFull, txEmpty, rxFull, rxEmpty;
  logic txDataWr, rxDataRd, clearWr;
  logic txOvfEv, rxOvfEv, rxUdfEv;
  logic thrValid;
  logic [EVENT_N-1:0] rawEv, maskedEv;
  logic [4:0] status;

  function automatic logic wrHit(input int unsigned a);
    return regWrEn && (regAddr == ADDR_W'(a));
  endfunction

  assign txFull  = (txLevel == CNT_W'(DEPTH));
  assign txEmpty = (txLevel == '0);
  assign rxFull  = (rxLevel == CNT_W'(DEPTH));
  assign rxEmpty = (rxLevel == '0);

  assign txDataWr = wrHit(A_TXDATA);
  assign clearWr  = wrHit(A_CLEAR);
  assign rxDataRd = regRdEn && (regAddr == ADDR_W'(A_RXDATA));
  assign thrValid = (regWrData < DATA_W'(DEPTH));

  // Strobes toward the datapath
  always_comb begin
    strb.flush  = !enableQ;
    strb.txPush = txDataWr && enableQ && !txFull;
    strb.txPop  = txPop && !txEmpty;
    strb.rxPush = rxPush && enableQ && !rxFull;
    strb.rxPop  = rxDataRd && !rxEmpty;
  end

  assign txOvfEv = txDataWr && enableQ && txFull;
  assign rxOvfEv = rxPush && enableQ && rxFull;
  assign rxUdfEv = rxDataRd && rxEmpty;

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      txThrQ  <= '0;
      rxThrQ  <= '0;
      maskQ   <= '0;
      dmaCtlQ <= '0;
      txWmQ   <= '0;
      rxWmQ   <= '0;
    end else begin
      if (wrHit(A_ENABLE))             enableQ <= regWrData[0];
      if (wrHit(A_TXTHR) && thrValid)  txThrQ  <= regWrData[PTR_W-1:0];
      if (wrHit(A_RXTHR) && thrValid)  rxThrQ  <= regWrData[PTR_W-1:0];
      if (wrHit(A_MASK))               maskQ   <= regWrData[EVENT_N-1:0];
      if (wrHit(A_DMACTL))             dmaCtlQ <= regWrData[1:0];
      if (wrHit(A_TXWM))               txWmQ   <= regWrData[CNT_W-1:0];
      if (wrHit(A_RXWM))               rxWmQ   <= regWrData[CNT_W-1:0];
    end
  end

  // Sticky event flags: a new event in the same cycle wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOvfQ <= 1'b0;
      rxUdfQ <= 1'b0;
      rxOvfQ <= 1'b0;
    end else begin
      txOvfQ <= txOvfEv || (txOvfQ && !(clearWr && (regWrData[0] || regWrData[3])));
      rxUdfQ <= rxUdfEv || (rxUdfQ && !(clearWr && (regWrData[0] || regWrData[1])));
      rxOvfQ <= rxOvfEv || (rxOvfQ && !(clearWr && (regWrData[0] || regWrData[2])));
    end
  end

  assign rawEv = {
    (rxLevel > CNT_W'(rxThrQ)),
    rxOvfQ,
    rxUdfQ,
    txOvfQ,
    (txLevel <= CNT_W'(txThrQ))
  };
  assign maskedEv = rawEv & maskQ;
  assign irq      = |maskedEv;

  assign status = {rxFull, rxEmpty, txEmpty, txFull, engBusy || (enableQ && !txEmpty)};

  assign txDmaReq = dmaCtlQ[1] && (txLevel <= txWmQ);
  assign rxDmaReq = dmaCtlQ[0] && (rxLevel > rxWmQ);
  assign txValid  = !txEmpty;
  assign enabled  = enableQ;

  // Read multiplexer
  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      case (regAddr)
        ADDR_W'(A_ENABLE): regRdData = DATA_W'(enableQ);
        ADDR_W'(A_TXTHR):  regRdData = DATA_W'(txThrQ);
        ADDR_W'(A_RXTHR):  regRdData = DATA_W'(rxThrQ);
        ADDR_W'(A_TXLVL):  regRdData = DATA_W'(txLevel);
        ADDR_W'(A_RXLVL):  regRdData = DATA_W'(rxLevel);
        ADDR_W'(A_STATUS): regRdData = DATA_W'(status);
        ADDR_W'(A_MASK):   regRdData = DATA_W'(maskQ);
        ADDR_W'(A_MASKED): regRdData = DATA_W'(maskedEv);
        ADDR_W'(A_RAW):    regRdData = DATA_W'(rawEv);
        ADDR_W'(A_DMACTL): regRdData = DATA_W'(dmaCtlQ);
        ADDR_W'(A_TXWM):   regRdData = DATA_W'(txWmQ);
        ADDR_W'(A_RXWM):   regRdData = DATA_W'(rxWmQ);
        ADDR_W'(A_RXDATA): regRdData = rxEmpty ? '0 : rxHead;
        default:           regRdData = '0;
      endcase
    end
  end

  // txHead is consumed by the engine directly; keep it visible here for width checks
  logic unusedHead;
  assign unusedHead = ^txHead;
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit import sfc_pkg::*; #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] txWord,
  output logic              txValid,
  input  logic              txPop,
  input  logic [DATA_W-1:0] rxWord,
  input  logic              rxPush,
  input  logic              engBusy,
  output logic              irq,
  output logic              txDmaReq,
  output logic              rxDmaReq
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  fifoStrobes_t      strb;
  logic              enabled;
  logic [DATA_W-1:0] txHead, rxHead;
  logic [CNT_W-1:0]  txLevel, rxLevel;

  sfc_control #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .txPop     (txPop),
    .rxPush    (rxPush),
    .engBusy   (engBusy),
    .txHead    (txHead),
    .rxHead    (rxHead),
    .txLevel   (txLevel),
    .rxLevel   (rxLevel),
    .strb      (strb),
    .enabled   (enabled),
    .txValid   (txValid),
    .irq       (irq),
    .txDmaReq  (txDmaReq),
    .rxDmaReq  (rxDmaReq)
  );

  sfc_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .txIn    (regWrData),
    .rxIn    (rxWord),
    .txHead  (txHead),
    .rxHead  (rxHead),
    .txLevel (txLevel),
    .rxLevel (rxLevel)
  );

  assign txWord = txHead;
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker import sfc_pkg::*; #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       regWrEn,
  input logic                       regRdEn,
  input logic [ADDR_W-1:0]          regAddr,
  input logic [DATA_W-1:0]          regRdData,
  input logic                       txPop,
  input logic                       rxPush,
  input logic                       enabled,
  input logic [$clog2(DEPTH+1)-1:0] txLevel,
  input logic [$clog2(DEPTH+1)-1:0] rxLevel
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic txWrite, rxRead;
  assign txWrite = regWrEn && (regAddr == ADDR_W'(A_TXDATA));
  assign rxRead  = regRdEn && (regAddr == ADDR_W'(A_RXDATA));

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= CNT_W'(DEPTH)) && (rxLevel <= CNT_W'(DEPTH)));

  // R3
  rx_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxRead && rxLevel != '0 && !rxPush) |=> (rxLevel == $past(rxLevel) - 1'b1));

  // R5
  tx_overflow_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txWrite && enabled && txLevel == CNT_W'(DEPTH) && !txPop) |=> (txLevel == CNT_W'(DEPTH)));

  // R6
  rx_underflow_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxRead && rxLevel == '0) |-> (regRdData == '0));

  // R6
  rx_overflow_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && enabled && rxLevel == CNT_W'(DEPTH) && !rxRead) |=> (rxLevel == CNT_W'(DEPTH)));

  // R12
  flush_when_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |=> (txLevel == '0 && rxLevel == '0));
endmodule

bind spi_fifo_irq_unit sfc_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regRdEn   (regRdEn),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .txPop     (txPop),
  .rxPush    (rxPush),
  .enabled   (enabled),
  .txLevel   (txLevel),
  .rxLevel   (rxLevel)
);

// File: tb/spi_fifo_irq_unit_tb.sv
module spi_fifo_irq_unit_tb;
  localparam int unsigned DEPTH  = 8;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0, regRdEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic [DATA_W-1:0] txWord;
  logic              txValid;
  logic              txPop = 1'b0;
  logic [DATA_W-1:0] rxWord = '0;
  logic              rxPush = 1'b0;
  logic              engBusy = 1'b0;
  logic              irq, txDmaReq, rxDmaReq;

  int checks = 0;
  int fails  = 0;
  logic [DATA_W-1:0] got;

  always #5 clk = ~clk;

  spi_fifo_irq_unit #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .txWord(txWord), .txValid(txValid), .txPop(txPop),
    .rxWord(rxWord), .rxPush(rxPush), .engBusy(engBusy),
    .irq(irq), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int unsigned a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = ADDR_W'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int unsigned a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = ADDR_W'(a);
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic engPop(output logic [DATA_W-1:0] d);
    @(negedge clk);
    txPop = 1'b1;
    #1 d = txWord;
    @(negedge clk);
    txPop = 1'b0;
  endtask

  task automatic engPush(input logic [DATA_W-1:0] d);
    @(negedge clk);
    rxPush = 1'b1; rxWord = d;
    @(negedge clk);
    rxPush = 1'b0;
  endtask

  // {req[3:0], isRead, addr[5:0], data/expected[15:0]}
  localparam int unsigned NV = 24;
  localparam logic [26:0] VEC [NV] = '{
    {4'd12, 1'b0, 6'h00, 16'h0001},  // R12 enable
    {4'd2,  1'b0, 6'h10, 16'h00A1},  // R2
    {4'd2,  1'b0, 6'h10, 16'h00B2},  // R2
    {4'd2,  1'b0, 6'h10, 16'h00C3},  // R2
    {4'd2,  1'b1, 6'h03, 16'h0003},  // R2 level
    {4'd4,  1'b1, 6'h05, 16'h0009},  // R4 busy + rx empty
    {4'd3,  1'b1, 6'h04, 16'h0000},  // R3
    {4'd10, 1'b0, 6'h01, 16'h0002},  // R10
    {4'd10, 1'b1, 6'h01, 16'h0002},  // R10
    {4'd7,  1'b1, 6'h08, 16'h0000},  // R7 level 3 above threshold 2
    {4'd10, 1'b0, 6'h01, 16'h0009},  // R10 too large
    {4'd10, 1'b1, 6'h01, 16'h0002},  // R10
    {4'd10, 1'b0, 6'h01, 16'h0008},  // R10 equal to depth
    {4'd10, 1'b1, 6'h01, 16'h0002},  // R10
    {4'd10, 1'b0, 6'h01, 16'h0007},  // R10 largest legal
    {4'd10, 1'b1, 6'h01, 16'h0007},  // R10
    {4'd7,  1'b1, 6'h08, 16'h0001},  // R7 level 3 at or below 7
    {4'd8,  1'b0, 6'h06, 16'h001F},  // R8
    {4'd8,  1'b1, 6'h07, 16'h0001},  // R8
    {4'd8,  1'b0, 6'h06, 16'h0000},  // R8
    {4'd8,  1'b1, 6'h07, 16'h0000},  // R8
    {4'd9,  1'b1, 6'h09, 16'h0000},  // R9 clear reads zero
    {4'd10, 1'b0, 6'h02, 16'h0008},  // R10 receive threshold
    {4'd10, 1'b1, 6'h02, 16'h0000}   // R10
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd('h05, got); check("R1", got, 16'd12, "status");
    rd('h08, got); check("R1", got, 16'd1, "raw events");
    rd('h03, got); check("R1", got, 16'd0, "tx level");
    rd('h04, got); check("R1", got, 16'd0, "rx level");
    rd('h01, got); check("R1", got, 16'd0, "tx threshold");
    check("R1", {13'd0, irq, txDmaReq, rxDmaReq}, 16'd0, "irq/dma");
    check("R1", {15'd0, txValid}, 16'd0, "txValid");

    // R4 busy follows the engine
    engBusy = 1'b1;
    rd('h05, got); check("R4", got, 16'd13, "status engine busy");
    engBusy = 1'b0;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][22]) begin
        rd(int'(VEC[i][21:16]), got);
        checks++;
        if (got !== VEC[i][15:0]) begin
          fails++;
          $display("FAIL R%0d vector %0d: got 0x%0h expected 0x%0h",
                   VEC[i][26:23], i, got, VEC[i][15:0]);
        end
      end else begin
        wr(int'(VEC[i][21:16]), VEC[i][15:0]);
      end
    end

    // R2 engine drains in order
    engPop(got); check("R2", got, 16'h00A1, "first head");
    engPop(got); check("R2", got, 16'h00B2, "second head");
    rd('h03, got); check("R2", got, 16'd1, "level after two pops");
    engPop(got); check("R2", got, 16'h00C3, "third head");
    #1 check("R2", {15'd0, txValid}, 16'd0, "txValid after drain");

    // R5 transmit overflow
    for (int i = 0; i < 8; i++) wr('h10, 16'h0100 + 16'(i));
    rd('h05, got); check("R4", got, 16'd11, "status tx full");
    wr('h10, 16'hDEAD);
    rd('h03, got); check("R5", got, 16'd8, "level after overflow");
    rd('h08, got); check("R5", got, 16'h0002, "raw after overflow");
    for (int i = 0; i < 8; i++) begin
      engPop(got);
      check("R5", got, 16'h0100 + 16'(i), "drain after overflow");
    end
    #1 check("R5", {15'd0, txValid}, 16'd0, "dropped word absent");

    // R3 / R6 receive path
    engPush(16'h0055);
    engPush(16'h0066);
    rd('h04, got); check("R3", got, 16'd2, "rx level");
    rd('h08, got); check("R7", got, 16'h0013, "raw rx above threshold");
    rd('h20, got); check("R3", got, 16'h0055, "rx oldest");
    rd('h20, got); check("R3", got, 16'h0066, "rx next");
    rd('h20, got); check("R6", got, 16'h0000, "underflow read");
    rd('h08, got); check("R6", got, 16'h0007, "raw after underflow");
    for (int i = 0; i < 8; i++) engPush(16'h0200 + 16'(i));
    rd('h05, got); check("R4", got, 16'd20, "status rx full");
    engPush(16'h02FF);
    rd('h04, got); check("R6", got, 16'd8, "rx level after overflow");
    rd('h08, got); check("R6", got, 16'h001F, "raw after rx overflow");
    rd('h20, got); check("R6", got, 16'h0200, "oldest kept");

    // R8 interrupt output
    wr('h06, 16'h0008);
    #1 check("R8", {15'd0, irq}, 16'd1, "irq with rx overflow masked in");
    rd('h07, got); check("R8", got, 16'h0008, "masked word");

    // R9 per-source clears
    wr('h09, 16'h0002);
    rd('h08, got); check("R9", got, 16'h001B, "clear underflow");
    wr('h09, 16'h0004);
    rd('h08, got); check("R9", got, 16'h0013, "clear rx overflow");
    #1 check("R8", {15'd0, irq}, 16'd0, "irq after clear");
    wr('h09, 16'h0008);
    rd('h08, got); check("R9", got, 16'h0011, "clear tx overflow");
    engPush(16'h0300);
    engPush(16'h0301);
    for (int i = 0; i < 9; i++) wr('h10, 16'h0400 + 16'(i));
    rd('h08, got); check("R9", got, 16'h001A, "sticky set again");
    wr('h09, 16'h0001);
    rd('h08, got); check("R9", got, 16'h0010, "clear all");

    // R11 DMA requests (tx level 8, rx level 8)
    wr('h0A, 16'h0003);
    wr('h0B, 16'h0002);
    wr('h0C, 16'h0001);
    #1 check("R11", {14'd0, txDmaReq, rxDmaReq}, 16'b01, "dma at full");
    for (int i = 0; i < 6; i++) engPop(got);
    for (int i = 0; i < 7; i++) rd('h20, got);
    #1 check("R11", {14'd0, txDmaReq, rxDmaReq}, 16'b10, "dma near empty");
    wr('h0A, 16'h0000);
    #1 check("R11", {14'd0, txDmaReq, rxDmaReq}, 16'b00, "dma disabled");

    // R12 disable flushes and ignores traffic
    wr('h00, 16'h0000);
    rd('h03, got); check("R12", got, 16'd0, "tx flushed");
    rd('h04, got); check("R12", got, 16'd0, "rx flushed");
    wr('h10, 16'h0777);
    engPush(16'h0888);
    rd('h03, got); check("R12", got, 16'd0, "tx write ignored");
    rd('h04, got); check("R12", got, 16'd0, "rx push ignored");
    rd('h08, got); check("R12", got, 16'h0001, "no overflow while disabled");
    wr('h00, 16'h0001);
    wr('h10, 16'h0999);
    rd('h03, got); check("R12", got, 16'd1, "resumes after enable");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule